// File: doc/BRIEF.md
# ATA Host Strobe Timing Engine

This block is the host-side sequencer that turns a single transfer request into correctly timed ATA-style write or read strobes. It drives the device data bus and its output enable. In multiword DMA mode it also runs the request/acknowledge handshake with the drive. Three programmable cycle counts shape every transfer: the setup interval before the first strobe, the width of each active strobe pulse, and the recovery time after it. Down-counters apply these counts, so one instance can serve many transfer-mode timings without changes to the hardware.

Write data is placed on the bus on the same clock edge that the write strobe goes active. It stays unchanged until the next active edge. The drive latches on the rising (inactive) edge, so the whole pulse serves as setup time and the whole recovery interval serves as hold time. For reads, the bus is sampled on the final cycle of the active pulse and kept in a holding register. A PIO request moves one word. A DMA request keeps striking strobes for as long as the drive holds its request line high. A one-cycle done pulse closes each word (PIO) or each burst (DMA).

Top module: `ata_strobe_engine`

## Requirements
- R1: When the engine accepts a request at clock edge E0, it stays in setup for `cfg_setup` cycles. It then holds the selected strobe low for `cfg_active` cycles, then high for `cfg_recover` cycles of recovery.
- R2: A timing value of 0 behaves exactly like a value of 1.
- R3: For writes, `bus_out` takes the value of `wr_word` on the edge where `wr_strobe_n` falls. `bus_out` does not change again until the next falling edge of `wr_strobe_n`.
- R4: `bus_oe` rises together with the first falling edge of `wr_strobe_n`. It falls when the final recovery ends. It is never high during a read.
- R5: For reads, `rd_word` captures `bus_in` on the last cycle of each active pulse and holds it through recovery and beyond.
- R6: In DMA mode (`xfer_dma`=1), `dma_ack_n` is low from E0 until the final recovery ends. When `dma_req` is high on the last recovery cycle, the next strobe starts at once with no new setup.
- R7: In PIO mode (`xfer_dma`=0), `dma_ack_n` stays high and exactly one strobe pulse is issued.
- R8: `xfer_done` is high for exactly one cycle, on the cycle the engine returns to idle (E0 + setup + words×(active+recovery)).
- R9: A request made while a transfer is in progress is ignored. It does not change the running waveform and does not start a further transfer.
- R10: The engine samples the timing inputs only when it accepts a request. Changes during a transfer do not affect that transfer.
- R11: After reset both strobes and `dma_ack_n` are high, and `bus_oe` and `xfer_done` are low. The two strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ATA timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_active | input | CW | Strobe active width in cycles |
| cfg_recover | input | CW | Strobe recovery width in cycles |
| cfg_setup | input | CW | Setup cycles before first strobe |
| xfer_req | input | 1 | Transfer request, taken when idle |
| xfer_write | input | 1 | 1 = write, 0 = read |
| xfer_dma | input | 1 | 1 = multiword DMA burst, 0 = PIO word |
| wr_word | input | DW | Write word, sampled at each strobe fall |
| xfer_done | output | 1 | One-cycle completion pulse |
| rd_word | output | DW | Captured read word |
| bus_in | input | DW | Device data bus input |
| bus_out | output | DW | Device data bus output |
| bus_oe | output | 1 | Data bus output enable |
| wr_strobe_n | output | 1 | Active-low write strobe |
| rd_strobe_n | output | 1 | Active-low read strobe |
| dma_req | input | 1 | Drive DMA request |
| dma_ack_n | output | 1 | Active-low DMA acknowledge |

## Verification
A corrupted phase counter or phase register shows up at once as a strobe edge on the wrong cycle. The handshake and done timing then slip by the same number of cycles. The bench therefore compares every output on every cycle of each transfer against a schedule built from the three counts. A missed data launch, or a write that changes data too early, shows on `bus_out` within the same pulse. A bad read capture shows on `rd_word` in the first recovery cycle after that pulse.

// File: rtl/ata_strobe_pkg.sv
package ata_strobe_pkg;

   typedef enum logic [1:0] {
      PH_IDLE    = 2'd0,
      PH_SETUP   = 2'd1,
      PH_ACTIVE  = 2'd2,
      PH_RECOVER = 2'd3
   } phase_e;

   localparam int FIELD_SETUP   = 0;
   localparam int FIELD_ACTIVE  = 1;
   localparam int FIELD_RECOVER = 2;
   localparam int NUM_FIELDS    = 3;

endpackage

// File: rtl/ata_timing_snapshot.sv
module ata_timing_snapshot #(
   parameter int CW = 8,
   parameter int NF = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic [NF*CW-1:0] raw,
   output logic [NF*CW-1:0] live,
   output logic [NF*CW-1:0] held
);

   localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

   for (genvar f = 0; f < NF; f++) begin : g_field
      logic [CW-1:0] raw_f;
      logic [CW-1:0] live_f;
      logic [CW-1:0] held_q;

      assign raw_f  = raw[f*CW +: CW];
      assign live_f = (raw_f == '0) ? ONE : raw_f;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    held_q <= ONE;
         else if (load) held_q <= live_f;
      end

      assign live[f*CW +: CW] = live_f;
      assign held[f*CW +: CW] = held_q;

      AST_HELD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
         held_q != '0);  // R2
   end

endmodule

// File: rtl/ata_phase_counter.sv
module ata_phase_counter #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          run,
   output logic          last
);

   localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= ONE;
      else if (load)             cnt_q <= load_val;
      else if (run && cnt_q > ONE) cnt_q <= cnt_q - ONE;
   end

   assign last = (cnt_q == ONE);

   AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt_q != '0));  // R2

endmodule

// File: rtl/ata_data_path.sv
module ata_data_path #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          launch,
   input  logic [DW-1:0] wr_word,
   input  logic          capture,
   input  logic [DW-1:0] bus_in,
   input  logic          oe_set,
   input  logic          oe_clr,
   output logic [DW-1:0] bus_out,
   output logic          bus_oe,
   output logic [DW-1:0] rd_word
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_out <= '0;
         rd_word <= '0;
         bus_oe  <= 1'b0;
      end else begin
         if (launch)  bus_out <= wr_word;
         if (capture) rd_word <= bus_in;
         if (oe_set)      bus_oe <= 1'b1;
         else if (oe_clr) bus_oe <= 1'b0;
      end
   end

   AST_NO_SET_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      !(oe_set && oe_clr));  // R4

endmodule

// File: rtl/ata_strobe_engine.sv
module ata_strobe_engine
   import ata_strobe_pkg::*;
#(
   parameter int CW     = 8,
   parameter int DW     = 16,
   parameter bit DMA_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] cfg_active,
   input  logic [CW-1:0] cfg_recover,
   input  logic [CW-1:0] cfg_setup,
   input  logic          xfer_req,
   input  logic          xfer_write,
   input  logic          xfer_dma,
   input  logic [DW-1:0] wr_word,
   output logic          xfer_done,
   output logic [DW-1:0] rd_word,
   input  logic [DW-1:0] bus_in,
   output logic [DW-1:0] bus_out,
   output logic          bus_oe,
   output logic          wr_strobe_n,
   output logic          rd_strobe_n,
   input  logic          dma_req,
   output logic          dma_ack_n
);

   localparam int FW = NUM_FIELDS * CW;

   if (CW < 2) begin : g_bad_cw
      $error("ata_strobe_engine: CW must be at least 2");
   end
   if (DW < 1) begin : g_bad_dw
      $error("ata_strobe_engine: DW must be at least 1");
   end

   logic req_dma_ok;
   if (DMA_EN) begin : g_dma
      assign req_dma_ok = xfer_dma;
   end else begin : g_pio_only
      assign req_dma_ok = 1'b0;
   end

   phase_e        state_q, state_nxt;
   logic          is_wr_q, is_dma_q;
   logic          accept, wr_eff, dma_eff;
   logic          ph_last, cnt_load;
   logic [CW-1:0] cnt_val;
   logic [FW-1:0] cfg_raw, cfg_live, cfg_held;
   logic          launch, capture, oe_clr, done_nxt;

   assign cfg_raw = {cfg_recover, cfg_active, cfg_setup};
   assign accept  = (state_q == PH_IDLE) && xfer_req;
   assign wr_eff  = accept ? xfer_write : is_wr_q;
   assign dma_eff = accept ? req_dma_ok : is_dma_q;

   ata_timing_snapshot #(.CW(CW), .NF(NUM_FIELDS)) u_snap (
      .clk  (clk),
      .rst_n(rst_n),
      .load (accept),
      .raw  (cfg_raw),
      .live (cfg_live),
      .held (cfg_held)
   );

   ata_phase_counter #(.CW(CW)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (cnt_load),
      .load_val(cnt_val),
      .run     (state_q != PH_IDLE),
      .last    (ph_last)
   );

   always_comb begin
      state_nxt = state_q;
      cnt_load  = 1'b0;
      cnt_val   = cfg_held[FIELD_ACTIVE*CW +: CW];
      done_nxt  = 1'b0;
      case (state_q)
         PH_IDLE: if (accept) begin
            state_nxt = PH_SETUP;
            cnt_load  = 1'b1;
            cnt_val   = cfg_live[FIELD_SETUP*CW +: CW];
         end
         PH_SETUP: if (ph_last) begin
            state_nxt = PH_ACTIVE;
            cnt_load  = 1'b1;
            cnt_val   = cfg_held[FIELD_ACTIVE*CW +: CW];
         end
         PH_ACTIVE: if (ph_last) begin
            state_nxt = PH_RECOVER;
            cnt_load  = 1'b1;
            cnt_val   = cfg_held[FIELD_RECOVER*CW +: CW];
         end
         PH_RECOVER: if (ph_last) begin
            if (is_dma_q && dma_req) begin
               state_nxt = PH_ACTIVE;
               cnt_load  = 1'b1;
               cnt_val   = cfg_held[FIELD_ACTIVE*CW +: CW];
            end else begin
               state_nxt = PH_IDLE;
               done_nxt  = 1'b1;
            end
         end
         default: state_nxt = PH_IDLE;
      endcase
   end

   assign launch  = (state_nxt == PH_ACTIVE) && (state_q != PH_ACTIVE) && is_wr_q;
   assign capture = (state_q == PH_ACTIVE) && ph_last && !is_wr_q;
   assign oe_clr  = done_nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= PH_IDLE;
         is_wr_q     <= 1'b0;
         is_dma_q    <= 1'b0;
         xfer_done   <= 1'b0;
         wr_strobe_n <= 1'b1;
         rd_strobe_n <= 1'b1;
         dma_ack_n   <= 1'b1;
      end else begin
         state_q     <= state_nxt;
         is_wr_q     <= wr_eff;
         is_dma_q    <= dma_eff;
         xfer_done   <= done_nxt;
         wr_strobe_n <= !((state_nxt == PH_ACTIVE) && wr_eff);
         rd_strobe_n <= !((state_nxt == PH_ACTIVE) && !wr_eff);
         dma_ack_n   <= !((state_nxt != PH_IDLE) && dma_eff);
      end
   end

   ata_data_path #(.DW(DW)) u_data (
      .clk    (clk),
      .rst_n  (rst_n),
      .launch (launch),
      .wr_word(wr_word),
      .capture(capture),
      .bus_in (bus_in),
      .oe_set (launch),
      .oe_clr (oe_clr),
      .bus_out(bus_out),
      .bus_oe (bus_oe),
      .rd_word(rd_word)
   );

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !(!wr_strobe_n && !rd_strobe_n));  // R11

   AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe && !$fell(wr_strobe_n)) |-> $stable(bus_out));  // R3

   AST_OE_NOT_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_strobe_n |-> !bus_oe);  // R4

   AST_OE_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_oe) |-> $fell(wr_strobe_n));  // R4

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |=> !xfer_done);  // R8

   AST_STROBE_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (is_dma_q && (!wr_strobe_n || !rd_strobe_n)) |-> !dma_ack_n);  // R6

endmodule

// File: tb/ata_strobe_engine_bench.sv
module ata_strobe_engine_bench;

   localparam int CW = 8;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [CW-1:0] cfg_active = '0, cfg_recover = '0, cfg_setup = '0;
   logic          xfer_req = 1'b0, xfer_write = 1'b0, xfer_dma = 1'b0;
   logic [DW-1:0] wr_word = '0, bus_in = '0;
   logic          dma_req = 1'b0;
   logic          xfer_done, bus_oe, wr_strobe_n, rd_strobe_n, dma_ack_n;
   logic [DW-1:0] rd_word, bus_out;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   ata_strobe_engine #(.CW(CW), .DW(DW), .DMA_EN(1'b1)) u_ata_strobe_engine (
      .clk(clk), .rst_n(rst_n),
      .cfg_active(cfg_active), .cfg_recover(cfg_recover), .cfg_setup(cfg_setup),
      .xfer_req(xfer_req), .xfer_write(xfer_write), .xfer_dma(xfer_dma),
      .wr_word(wr_word), .xfer_done(xfer_done), .rd_word(rd_word),
      .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
      .wr_strobe_n(wr_strobe_n), .rd_strobe_n(rd_strobe_n),
      .dma_req(dma_req), .dma_ack_n(dma_ack_n)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic t_reset;
      check({wr_strobe_n, rd_strobe_n, dma_ack_n, bus_oe, xfer_done} == 5'b11100,
            "R11 reset state", {wr_strobe_n, rd_strobe_n, dma_ack_n, bus_oe, xfer_done}, 5'b11100);
   endtask

   // Runs one request and compares every output each cycle with a schedule from the counts.
   task automatic run_xfer(input bit wr, input bit dma, input int a_raw, input int r_raw,
                           input int s_raw, input int n, input bit poke, input bit cfgchg,
                           input string tag);
      int ea, er, es, per, total, seed;
      logic [DW-1:0] wd [8];
      logic [DW-1:0] rdw[8];
      ea = (a_raw == 0) ? 1 : a_raw;
      er = (r_raw == 0) ? 1 : r_raw;
      es = (s_raw == 0) ? 1 : s_raw;
      per = ea + er;
      total = es + n * per;
      seed = a_raw * 7 + r_raw * 13 + s_raw * 29 + n;
      for (int i = 0; i < 8; i++) begin
         wd[i]  = DW'(16'h1234 * (i + 1) + seed);
         rdw[i] = DW'(16'hA5C3 ^ (16'h0101 * (i + 3)) ^ seed);
      end
      @(negedge clk);
      cfg_active = CW'(a_raw); cfg_recover = CW'(r_raw); cfg_setup = CW'(s_raw);
      xfer_write = wr; xfer_dma = dma; xfer_req = 1'b1;
      wr_word = wd[0]; bus_in = rdw[0]; dma_req = dma;
      for (int j = 0; j <= total; j++) begin
         int k, w, r, wn;
         bit act_ph, in_x;
         logic [4:0] exp_v, got_v;
         @(posedge clk);
         @(negedge clk);
         if (j == 0) xfer_req = 1'b0;
         in_x = (j < total);
         k = j - es;
         w = (k >= 0) ? k / per : 0;
         r = (k >= 0) ? k % per : 0;
         act_ph = in_x && (k >= 0) && (r < ea);
         exp_v = {!(wr && act_ph), !(!wr && act_ph), !(dma && in_x),
                  wr && in_x && (k >= 0), (j == total)};
         got_v = {wr_strobe_n, rd_strobe_n, dma_ack_n, bus_oe, xfer_done};
         check(got_v == exp_v, $sformatf("R1 R4 R6 R7 R8 R9 R10 %s cycle %0d", tag, j),
               32'(got_v), 32'(exp_v));
         if (wr && in_x && k >= 0)
            check(bus_out == wd[w], $sformatf("R3 %s data word %0d", tag, w), 32'(bus_out), 32'(wd[w]));
         if (!wr && in_x && k >= 0 && r >= ea)
            check(rd_word == rdw[w], $sformatf("R5 %s capture word %0d", tag, w), 32'(rd_word), 32'(rdw[w]));
         if (cfgchg && j == 0) begin
            cfg_active = 8'd9; cfg_recover = 8'd9; cfg_setup = 8'd9;
         end
         if (poke && j == es) begin
            xfer_req = 1'b1; xfer_write = !wr; xfer_dma = !dma;
         end
         if (poke && j == es + 1) xfer_req = 1'b0;
         wn = (j + 1 - es) / per;
         if (j + 1 - es < 0) wn = 0;
         if (wn > n - 1) wn = n - 1;
         wr_word = wd[wn];
         bus_in  = rdw[wn];
         dma_req = dma && (j + 1 < total);
      end
      if (!wr)
         check(rd_word == rdw[n-1], $sformatf("R5 %s held after done", tag), 32'(rd_word), 32'(rdw[n-1]));
      for (int q = 0; q < 4; q++) begin
         @(posedge clk);
         @(negedge clk);
         check({wr_strobe_n, rd_strobe_n, dma_ack_n, xfer_done} == 4'b1110,
               $sformatf("R9 %s idle after done", tag),
               32'({wr_strobe_n, rd_strobe_n, dma_ack_n, xfer_done}), 32'(4'b1110));
      end
   endtask

   task automatic t_pio_write;  run_xfer(1, 0, 3, 2, 2, 1, 0, 0, "pio_wr");  endtask
   task automatic t_pio_read;   run_xfer(0, 0, 4, 3, 1, 1, 0, 0, "pio_rd");  endtask
   task automatic t_dma_write;  run_xfer(1, 1, 2, 1, 3, 3, 0, 0, "dma_wr");  endtask
   task automatic t_dma_read;   run_xfer(0, 1, 1, 1, 1, 2, 0, 0, "dma_rd");  endtask
   task automatic t_dma_single; run_xfer(1, 1, 2, 2, 2, 1, 0, 0, "dma_one"); endtask
   task automatic t_zero_cfg;   run_xfer(1, 0, 0, 0, 0, 1, 0, 0, "R2_zero"); endtask
   task automatic t_busy_cfg;   run_xfer(1, 0, 2, 2, 2, 1, 1, 1, "R9_R10");  endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_pio_write();
      t_pio_read();
      t_dma_write();
      t_dma_read();
      t_dma_single();
      t_zero_cfg();
      t_busy_cfg();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule